// File: doc/BRIEF.md
# Single-Cell Linear Charge Sequencer

This block is the digital sequencer of a linear charger for one lithium cell. Analog comparators report the supply, the cell voltage, the charge current, the adjust pin and the die temperature. The block uses those flags to decide which charge current the regulation loop should target and whether the charge-status pin should pull low. A conditioning phase at low current brings a deeply discharged cell up, a full-current phase follows, and a top-off state holds the cell at low current until it sags and full charging resumes. Two safety timers guard the conditioning and full-current phases. When one expires, charging stops in a latched state.

Two events take effect from any state without waiting for a clock edge. Loss of supply zeroes the outputs and puts the sequencer in its power-down state. A thermal trip zeroes the outputs and puts it in thermal shutdown. Each event sets a flag that asserts asynchronously and releases synchronously. All other comparator flags pass through a two-flop synchronizer. Timer lengths are parameters given in timebase ticks, so a system can pick its own tick rate.

States: POWER_DOWN, START, PRECHARGE, FAST_CHARGE, END_OF_CHARGE, TIMEOUT, BATTERY_FAULT, SHUTDOWN. Transitions:
- POWER_DOWN to START on supply good.
- START to PRECHARGE or FAST_CHARGE when the start sequence ends.
- PRECHARGE to FAST_CHARGE when the cell clears the conditioning threshold.
- PRECHARGE to BATTERY_FAULT when the conditioning timer expires.
- FAST_CHARGE to END_OF_CHARGE when the top-off condition is met.
- FAST_CHARGE to TIMEOUT when the full-current timer expires.
- END_OF_CHARGE to FAST_CHARGE when the cell sags.
- START, PRECHARGE, FAST_CHARGE and END_OF_CHARGE to SHUTDOWN when the adjust pin is low.
- SHUTDOWN to START on release.
- Any state to POWER_DOWN on supply loss.
- Any state to SHUTDOWN on thermal trip.

Top module: `chg_seq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the block sits in POWER_DOWN with `iset_sel_o` = 2'b00 (zero current) and `stat_en_o` = 0.
- R2: When `supply_ok_i` goes low, `iset_sel_o` becomes 2'b00 and `stat_en_o` becomes 0 without a clock edge, and the state is POWER_DOWN. When the supply returns, START holds the outputs at zero for START_CYCLES clocks before charging begins.
- R3: When `temp_trip_i` goes high, the outputs go to zero without a clock edge and the state is SHUTDOWN. SHUTDOWN moves to START only once the trip has cleared, `temp_hot_i` is low and `adj_ok_i` is high.
- R4: While `adj_ok_i` is low, START, PRECHARGE, FAST_CHARGE and END_OF_CHARGE move to SHUTDOWN. A high level restarts the cycle through START.
- R5: At the end of START the block goes to PRECHARGE if `bat_pre_ok_i` is low (`iset_sel_o` = 2'b01, low current, `stat_en_o` = 1). Otherwise it goes to FAST_CHARGE (`iset_sel_o` = 2'b10, full current, `stat_en_o` = 1).
- R6: PRECHARGE moves to FAST_CHARGE once `bat_pre_ok_i` is high.
- R7: If PRE_TICKS ticks of `tick_i` arrive in PRECHARGE, the block enters BATTERY_FAULT, where the outputs are zero and `stat_en_o` is 0.
- R8: FAST_CHARGE moves to END_OF_CHARGE only when `cur_low_i` and `bat_float_ok_i` are both high. Neither flag alone does it. END_OF_CHARGE drives `iset_sel_o` = 2'b01 and `stat_en_o` = 0.
- R9: END_OF_CHARGE returns to FAST_CHARGE when `bat_float_ok_i` goes low.
- R10: If FAST_TICKS ticks arrive in FAST_CHARGE, the block enters TIMEOUT, where the outputs are zero and `stat_en_o` is 0.
- R11: TIMEOUT and BATTERY_FAULT ignore the adjust pin and the battery flags. They are left only through the supply-loss or thermal override.
- R12: The safety timer clears on every state entry, so each return to FAST_CHARGE allows a full FAST_TICKS again. `iset_sel_o` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply above its operating threshold |
| temp_trip_i | input | 1 | Die temperature above the thermal limit |
| temp_hot_i | input | 1 | Die temperature above the resume limit |
| adj_ok_i | input | 1 | Adjust pin above its shutdown threshold |
| bat_pre_ok_i | input | 1 | Cell above the conditioning threshold |
| bat_float_ok_i | input | 1 | Cell above the float threshold |
| cur_low_i | input | 1 | Charge current below one tenth of the set rate |
| tick_i | input | 1 | One-cycle timebase pulse for the safety timers |
| iset_sel_o | output | 2 | Current setpoint: 00 zero, 01 low, 10 full |
| stat_en_o | output | 1 | Charge-status pull-down enable |

## Verification
The bench builds the block with START_CYCLES = 4, PRE_TICKS = 6 and FAST_TICKS = 10. At those values both safety timeouts fall within a few hundred clocks. The bench can then stop one tick short of each limit, and it can show that a detour through END_OF_CHARGE restarts the full-current budget. The short start phase also leaves the zero-current window after supply return open to a direct check.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

    typedef enum logic [2:0] {
        ST_PWR_DOWN = 3'd0,
        ST_START    = 3'd1,
        ST_PRE      = 3'd2,
        ST_FAST     = 3'd3,
        ST_EOC      = 3'd4,
        ST_TIMEOUT  = 3'd5,
        ST_FAULT    = 3'd6,
        ST_SHUTDOWN = 3'd7
    } chg_state_e;

    typedef enum logic [1:0] {
        ISET_ZERO = 2'b00,
        ISET_LOW  = 2'b01,
        ISET_FULL = 2'b10
    } iset_e;

    typedef struct packed {
        logic bat_pre;
        logic bat_float;
        logic cur_low;
        logic adj_ok;
        logic temp_hot;
    } cmp_flags_t;

    localparam int unsigned CMP_W = $bits(cmp_flags_t);

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= '0;
                    else        stg[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= '0;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/chg_ovr.sv
module chg_ovr #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic temp_trip_i,
    output logic sup_good_o,
    output logic trip_hold_o
);
    logic [STAGES-1:0] sup_q;
    logic [STAGES-1:0] trip_q;

    // supply good: cleared at once on loss, released after STAGES edges
    always_ff @(posedge clk or negedge rst_n or negedge supply_ok_i) begin
        if (!rst_n)            sup_q <= '0;
        else if (!supply_ok_i) sup_q <= '0;
        else                   sup_q <= {sup_q[STAGES-2:0], 1'b1};
    end

    // thermal trip: set at once, released after STAGES edges
    always_ff @(posedge clk or negedge rst_n or posedge temp_trip_i) begin
        if (!rst_n)           trip_q <= '0;
        else if (temp_trip_i) trip_q <= '1;
        else                  trip_q <= {trip_q[STAGES-2:0], 1'b0};
    end

    assign sup_good_o  = sup_q[STAGES-1];
    assign trip_hold_o = trip_q[STAGES-1];
endmodule

// File: rtl/chg_timer.sv
module chg_timer #(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic [W-1:0] limit_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end

    // asserted on the event that completes the programmed count
    assign done_o = inc_i && (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl
    import chg_seq_pkg::*;
#(
    parameter int unsigned START_CYCLES = 16,
    parameter int unsigned PRE_TICKS    = 1800,
    parameter int unsigned FAST_TICKS   = 10800,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok_i,
    input  logic       temp_trip_i,
    input  logic       temp_hot_i,
    input  logic       adj_ok_i,
    input  logic       bat_pre_ok_i,
    input  logic       bat_float_ok_i,
    input  logic       cur_low_i,
    input  logic       tick_i,
    output logic [1:0] iset_sel_o,
    output logic       stat_en_o
);
    localparam int unsigned MAX_A = (START_CYCLES > PRE_TICKS) ? START_CYCLES : PRE_TICKS;
    localparam int unsigned MAX_L = (MAX_A > FAST_TICKS) ? MAX_A : FAST_TICKS;
    localparam int unsigned TW    = $clog2(MAX_L + 1);

    chg_state_e state_q, state_d;
    cmp_flags_t raw_flags, flags;
    logic       sup_good, trip_hold;
    logic       tmr_clr, tmr_inc, tmr_done;
    logic [TW-1:0] tmr_limit;
    iset_e      iset_st;
    logic       stat_st;

    assign raw_flags = '{bat_pre:   bat_pre_ok_i,
                         bat_float: bat_float_ok_i,
                         cur_low:   cur_low_i,
                         adj_ok:    adj_ok_i,
                         temp_hot:  temp_hot_i};

    chg_sync #(.W(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_flags),
        .q_o   (flags)
    );

    chg_ovr #(.STAGES(SYNC_STAGES)) u_ovr (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok_i),
        .temp_trip_i (temp_trip_i),
        .sup_good_o  (sup_good),
        .trip_hold_o (trip_hold)
    );

    // timer selection per state
    always_comb begin
        tmr_limit = TW'(FAST_TICKS);
        tmr_inc   = 1'b0;
        unique case (state_q)
            ST_START: begin tmr_limit = TW'(START_CYCLES); tmr_inc = 1'b1;   end
            ST_PRE:   begin tmr_limit = TW'(PRE_TICKS);    tmr_inc = tick_i; end
            ST_FAST:  begin tmr_limit = TW'(FAST_TICKS);   tmr_inc = tick_i; end
            default:  begin tmr_limit = TW'(FAST_TICKS);   tmr_inc = 1'b0;   end
        endcase
    end

    assign tmr_clr = (state_d != state_q);

    chg_timer #(.W(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tmr_clr),
        .inc_i   (tmr_inc),
        .limit_i (tmr_limit),
        .done_o  (tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PWR_DOWN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!sup_good) begin
            state_d = ST_PWR_DOWN;
        end else if (trip_hold) begin
            state_d = ST_SHUTDOWN;
        end else begin
            unique case (state_q)
                ST_PWR_DOWN: state_d = ST_START;
                ST_START: begin
                    if (!flags.adj_ok)     state_d = ST_SHUTDOWN;
                    else if (tmr_done)     state_d = flags.bat_pre ? ST_FAST : ST_PRE;
                end
                ST_PRE: begin
                    if (!flags.adj_ok)     state_d = ST_SHUTDOWN;
                    else if (tmr_done)     state_d = ST_FAULT;
                    else if (flags.bat_pre) state_d = ST_FAST;
                end
                ST_FAST: begin
                    if (!flags.adj_ok)     state_d = ST_SHUTDOWN;
                    else if (tmr_done)     state_d = ST_TIMEOUT;
                    else if (flags.cur_low && flags.bat_float) state_d = ST_EOC;
                end
                ST_EOC: begin
                    if (!flags.adj_ok)        state_d = ST_SHUTDOWN;
                    else if (!flags.bat_float) state_d = ST_FAST;
                end
                ST_TIMEOUT:  state_d = ST_TIMEOUT;
                ST_FAULT:    state_d = ST_FAULT;
                ST_SHUTDOWN: begin
                    if (flags.adj_ok && !flags.temp_hot) state_d = ST_START;
                end
                default:     state_d = ST_PWR_DOWN;
            endcase
        end
    end

    // outputs per state
    always_comb begin
        iset_st = ISET_ZERO;
        stat_st = 1'b0;
        unique case (state_q)
            ST_PRE:  begin iset_st = ISET_LOW;  stat_st = 1'b1; end
            ST_FAST: begin iset_st = ISET_FULL; stat_st = 1'b1; end
            ST_EOC:  begin iset_st = ISET_LOW;  stat_st = 1'b0; end
            default: begin iset_st = ISET_ZERO; stat_st = 1'b0; end
        endcase
    end

    // overrides cut the outputs before the state register catches up
    assign iset_sel_o = (sup_good && !trip_hold) ? iset_st : ISET_ZERO;
    assign stat_en_o  = sup_good && !trip_hold && stat_st;

endmodule

// File: rtl/chg_seq_ctrl_chk.sv
module chg_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok_i,
    input logic       temp_trip_i,
    input logic [1:0] iset_sel_o,
    input logic       stat_en_o,
    input logic [2:0] state_q
);
    localparam logic [2:0] S_PD    = 3'd0;
    localparam logic [2:0] S_PRE   = 3'd2;
    localparam logic [2:0] S_FAST  = 3'd3;
    localparam logic [2:0] S_EOC   = 3'd4;
    localparam logic [2:0] S_TMO   = 3'd5;
    localparam logic [2:0] S_FAULT = 3'd6;
    localparam logic [2:0] S_SHDN  = 3'd7;

    AST_SUPPLY_LOSS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |-> (iset_sel_o == 2'b00 && !stat_en_o)); // R2
    AST_TRIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        temp_trip_i |-> (iset_sel_o == 2'b00 && !stat_en_o)); // R3
    AST_ISET_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        iset_sel_o != 2'b11); // R12
    AST_STAT_NEEDS_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
        stat_en_o |-> (iset_sel_o != 2'b00)); // R5
    AST_FAULT_FROM_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FAULT && $past(state_q) != S_FAULT) |-> $past(state_q) == S_PRE); // R7
    AST_EOC_FROM_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EOC && $past(state_q) != S_EOC) |-> $past(state_q) == S_FAST); // R8
    AST_TIMEOUT_FROM_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TMO && $past(state_q) != S_TMO) |-> $past(state_q) == S_FAST); // R10
    AST_FAULT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FAULT) |=> (state_q == S_FAULT || state_q == S_PD || state_q == S_SHDN)); // R11
    AST_TIMEOUT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TMO) |=> (state_q == S_TMO || state_q == S_PD || state_q == S_SHDN)); // R11
endmodule

bind chg_seq_ctrl chg_seq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok_i (supply_ok_i),
    .temp_trip_i (temp_trip_i),
    .iset_sel_o  (iset_sel_o),
    .stat_en_o   (stat_en_o),
    .state_q     (state_q)
);

// File: tb/chg_seq_ctrl_test.sv
module chg_seq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int START_C = 4;
    localparam int PRE_T   = 6;
    localparam int FAST_T  = 10;
    localparam int SETTLE  = START_C + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1, temp_trip = 1'b0, temp_hot = 1'b0, adj_ok = 1'b1;
    logic bat_pre = 1'b0, bat_float = 1'b0, cur_low = 1'b0, tick = 1'b0;
    logic [1:0] iset;
    logic stat;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chg_seq_ctrl #(.START_CYCLES(START_C), .PRE_TICKS(PRE_T),
                   .FAST_TICKS(FAST_T), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .temp_trip_i(temp_trip),
        .temp_hot_i(temp_hot), .adj_ok_i(adj_ok), .bat_pre_ok_i(bat_pre),
        .bat_float_ok_i(bat_float), .cur_low_i(cur_low), .tick_i(tick),
        .iset_sel_o(iset), .stat_en_o(stat));

    task automatic check(input string req, input logic [1:0] exp_i, input logic exp_s);
        n_chk++;
        if (iset !== exp_i || stat !== exp_s) begin
            n_bad++;
            $display("FAIL %s: iset=%b stat=%b expected iset=%b stat=%b",
                     req, iset, stat, exp_i, exp_s);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
        wait_cyc(2);
    endtask

    task automatic supply_cycle();
        @(negedge clk) supply_ok = 1'b0;
        wait_cyc(3);
        supply_ok = 1'b1;
        wait_cyc(SETTLE);
    endtask

    task automatic t_reset();
        wait_cyc(3);
        check("R1 in reset", 2'b00, 1'b0);
        rst_n = 1'b1;
        wait_cyc(1);
        check("R1 after release", 2'b00, 1'b0);
        wait_cyc(SETTLE);
        check("R5 low cell to precharge", 2'b01, 1'b1);
    endtask

    task automatic t_pre_to_fast();
        bat_pre = 1'b1;
        wait_cyc(6);
        check("R6 precharge to fast", 2'b10, 1'b1);
    endtask

    task automatic t_eoc();
        cur_low = 1'b1;
        wait_cyc(6);
        check("R8 current low alone", 2'b10, 1'b1);
        cur_low = 1'b0; bat_float = 1'b1;
        wait_cyc(6);
        check("R8 float alone", 2'b10, 1'b1);
        cur_low = 1'b1;
        wait_cyc(6);
        check("R8 end of charge", 2'b01, 1'b0);
        bat_float = 1'b0;
        wait_cyc(6);
        check("R9 recharge", 2'b10, 1'b1);
        cur_low = 1'b0;
        wait_cyc(2);
    endtask

    task automatic t_adj();
        adj_ok = 1'b0;
        wait_cyc(6);
        check("R4 adjust low shuts down", 2'b00, 1'b0);
        adj_ok = 1'b1;
        wait_cyc(SETTLE);
        check("R4 restart to fast (R5)", 2'b10, 1'b1);
    endtask

    task automatic t_trip();
        @(negedge clk);
        temp_trip = 1'b1; temp_hot = 1'b1;
        #1;
        check("R3 trip is immediate", 2'b00, 1'b0);
        wait_cyc(4);
        temp_trip = 1'b0;
        wait_cyc(10);
        check("R3 hot blocks resume", 2'b00, 1'b0);
        temp_hot = 1'b0;
        wait_cyc(SETTLE);
        check("R3 resume after cooling", 2'b10, 1'b1);
    endtask

    task automatic t_supply();
        @(negedge clk);
        supply_ok = 1'b0;
        #1;
        check("R2 supply loss is immediate", 2'b00, 1'b0);
        wait_cyc(4);
        check("R2 held in power down", 2'b00, 1'b0);
        supply_ok = 1'b1;
        wait_cyc(3);
        check("R2 start phase holds zero", 2'b00, 1'b0);
        wait_cyc(SETTLE);
        check("R2 charging after start", 2'b10, 1'b1);
    endtask

    task automatic t_fast_timeout();
        pulse_ticks(FAST_T - 2);
        check("R10 fast below limit", 2'b10, 1'b1);
        cur_low = 1'b1; bat_float = 1'b1;
        wait_cyc(6);
        check("R8 end of charge again", 2'b01, 1'b0);
        bat_float = 1'b0; cur_low = 1'b0;
        wait_cyc(6);
        pulse_ticks(FAST_T - 1);
        check("R12 timer restarted on reentry", 2'b10, 1'b1);
        pulse_ticks(1);
        check("R10 fast timeout", 2'b00, 1'b0);
    endtask

    task automatic t_latched_timeout();
        adj_ok = 1'b0;
        wait_cyc(6);
        adj_ok = 1'b1; bat_float = 1'b1;
        wait_cyc(SETTLE);
        check("R11 timeout ignores adjust", 2'b00, 1'b0);
        bat_float = 1'b0;
        supply_cycle();
        check("R11 timeout left by power down", 2'b10, 1'b1);
    endtask

    task automatic t_pre_timeout();
        bat_pre = 1'b0;
        supply_cycle();
        check("R5 precharge after restart", 2'b01, 1'b1);
        pulse_ticks(PRE_T - 1);
        check("R7 precharge below limit", 2'b01, 1'b1);
        pulse_ticks(1);
        check("R7 battery fault", 2'b00, 1'b0);
        adj_ok = 1'b0;
        wait_cyc(6);
        adj_ok = 1'b1; bat_pre = 1'b1;
        wait_cyc(SETTLE);
        check("R11 fault ignores adjust and cell", 2'b00, 1'b0);
        bat_pre = 1'b0;
        supply_cycle();
        check("R11 fault left by power down", 2'b01, 1'b1);
    endtask

    initial begin
        t_reset();
        t_pre_to_fast();
        t_eoc();
        t_adj();
        t_trip();
        t_supply();
        t_fast_timeout();
        t_latched_timeout();
        t_pre_timeout();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule